// File: doc/BRIEF.md
# In-place quicksort controller

This block sorts, in place, an array of unsigned words held in a simple dual-port RAM that sits outside it. The array fills the whole RAM, 2^ADDR_W words of DATA_W bits. The controller drives one synchronous read port and one write port. Data comes back one clock after the read address is presented. When a read and a write hit the same address in one cycle, the RAM must return the old contents.

Partitioning keeps the last element of a range as the pivot. It streams the range once and exchanges each smaller element into a growing low region; each exchange costs two cycles. A small register stack holds index ranges. After each partition, the top entry is narrowed to the larger side and only the smaller side is pushed. This keeps the stack shallow whatever the input order.

The block has no data stream at its edge, so it has no valid/ready handshake. `start` is a plain pulse that is sampled only while `done` is high. `done` stays high for as long as the block is idle. The surrounding logic loads the RAM before the pulse and reads it back after `done` returns. It must not touch the RAM in between.

Top module: `qsort_ctrl`

## Requirements
- R1: After reset `done` is high, while `read_enable` and `write_enable` are low.
- R2: A `start` pulse seen while `done` is high makes `done` low and `read_enable` high on the following clock edge.
- R3: When `done` rises again, the RAM holds the original words in ascending order, as the same multiset.
- R4: `start` has no effect while a sort is running; the result is the same as without the extra pulse.
- R5: `read_enable` stays high on every cycle in which `done` is low.
- R6: A sort of 2^ADDR_W words finishes within 4·N² + 8·N cycles, where N = 2^ADDR_W.
- R7: The range stack pointer never exceeds ADDR_W. Entry 0 holds the whole array, and only the smaller partition is ever pushed.
- R8: Words are compared as unsigned numbers, so words with the top bit set sort above all the others.
- R9: Arrays that contain duplicates, including an array where every word is equal, are sorted correctly.
- R10: Input that is already ascending, and input that is descending, are sorted correctly.
- R11: `write_enable` is low on every cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sort; sampled only while idle |
| done | output | 1 | High while idle |
| read_enable | output | 1 | RAM read port enable |
| read_address | output | ADDR_W | RAM read address |
| read_data | input | DATA_W | RAM read data, valid one cycle after the address |
| write_enable | output | 1 | RAM write strobe |
| write_address | output | ADDR_W | RAM write address |
| write_data | output | DATA_W | RAM write data |

## Verification
Two things can happen in one cycle: the first half of an exchange writes a word to address i, and the RAM reads address i in that same cycle to fetch the word being displaced. The RAM must return the value from before the write. Inputs with many words below the pivot force this on almost every element. The degenerate case where i equals the scan position is hit as well. The bench drives these inputs, models a read-before-write RAM, and judges each run by comparing the final RAM contents, word for word, against a sorted copy the bench builds itself. Any lost or doubled word shows up as a mismatch.

// File: rtl/qs_pkg.sv
package qs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOP   = 3'd1,
    ST_PIVOT  = 3'd2,
    ST_SCAN   = 3'd3,
    ST_XCHG   = 3'd4,
    ST_PLACE  = 3'd5,
    ST_NARROW = 3'd6,
    ST_DEFER  = 3'd7
  } qs_state_e;

endpackage

// File: rtl/qs_range_stack.sv
module qs_range_stack #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = ADDR_W + 2,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic              set_pv,
  input  logic [ADDR_W-1:0] in_lo,
  input  logic [ADDR_W-1:0] in_hi,
  input  logic [ADDR_W-1:0] in_pv,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_lo,
  output logic [ADDR_W-1:0] top_hi,
  output logic [ADDR_W-1:0] top_pv,
  output logic              empty,
  output logic [PW-1:0]     ptr
);

  logic [ADDR_W-1:0] lo_m [DEPTH];
  logic [ADDR_W-1:0] hi_m [DEPTH];
  logic [ADDR_W-1:0] pv_m [DEPTH];
  logic [PW-1:0]     ptr_up;
  logic [PW-1:0]     ptr_dn;

  assign ptr_up = ptr + PW'(1);
  assign ptr_dn = ptr - PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (push) ptr <= ptr_up;
    else if (pop)  ptr <= ptr_dn;
  end

  // a push writes every field of the next slot; otherwise fields update in place
  always_ff @(posedge clk) begin
    if (push) begin
      lo_m[ptr_up] <= in_lo;
      hi_m[ptr_up] <= in_hi;
      pv_m[ptr_up] <= in_pv;
    end else begin
      if (set_lo) lo_m[ptr] <= in_lo;
      if (set_hi) hi_m[ptr] <= in_hi;
      if (set_pv) pv_m[ptr] <= in_pv;
    end
  end

  assign top_lo = lo_m[ptr];
  assign top_hi = hi_m[ptr];
  assign top_pv = pv_m[ptr];
  assign empty  = (ptr == '0);

endmodule

// File: rtl/qs_split_unit.sv
module qs_split_unit #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] pv,
  output logic              left_small,
  output logic [ADDR_W-1:0] pv_inc,
  output logic [ADDR_W-1:0] pv_dec,
  output logic              pv_at_min,
  output logic              pv_at_max
);

  logic [ADDR_W-1:0] left_len;
  logic [ADDR_W-1:0] right_len;

  // lo <= pv <= hi holds here, so neither difference wraps
  assign left_len   = pv - lo;
  assign right_len  = hi - pv;
  assign left_small = left_len < right_len;
  assign pv_inc     = pv + ADDR_W'(1);
  assign pv_dec     = pv - ADDR_W'(1);
  assign pv_at_min  = (pv == '0);
  assign pv_at_max  = (pv == '1);

endmodule

// File: rtl/qsort_ctrl.sv
module qsort_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              read_enable,
  output logic [ADDR_W-1:0] read_address,
  input  logic [DATA_W-1:0] read_data,
  output logic              write_enable,
  output logic [ADDR_W-1:0] write_address,
  output logic [DATA_W-1:0] write_data
);
  import qs_pkg::*;

  localparam int STK_DEPTH = ADDR_W + 2;
  localparam int PW        = $clog2(STK_DEPTH);

  qs_state_e st_q, st_d;

  logic [ADDR_W-1:0] i_q, i_d;
  logic [ADDR_W-1:0] j_q, j_d;
  logic [ADDR_W-1:0] jp_q, jp_d;
  logic [ADDR_W-1:0] keep_q, keep_d;
  logic [DATA_W-1:0] piv_q, piv_d;
  logic              lsm_q, lsm_d;
  logic              rden_q, rden_d;

  logic              s_set_lo, s_set_hi, s_set_pv, s_push, s_pop;
  logic [ADDR_W-1:0] s_in_lo, s_in_hi, s_in_pv;
  logic [ADDR_W-1:0] top_lo, top_hi, top_pv;
  logic              stk_empty;
  logic [PW-1:0]     stk_depth;

  logic              left_small, pv_at_min, pv_at_max;
  logic [ADDR_W-1:0] pv_inc, pv_dec;

  qs_range_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_lo (s_set_lo),
    .set_hi (s_set_hi),
    .set_pv (s_set_pv),
    .in_lo  (s_in_lo),
    .in_hi  (s_in_hi),
    .in_pv  (s_in_pv),
    .push   (s_push),
    .pop    (s_pop),
    .top_lo (top_lo),
    .top_hi (top_hi),
    .top_pv (top_pv),
    .empty  (stk_empty),
    .ptr    (stk_depth)
  );

  qs_split_unit #(.ADDR_W(ADDR_W)) u_split (
    .lo         (top_lo),
    .hi         (top_hi),
    .pv         (top_pv),
    .left_small (left_small),
    .pv_inc     (pv_inc),
    .pv_dec     (pv_dec),
    .pv_at_min  (pv_at_min),
    .pv_at_max  (pv_at_max)
  );

  always_comb begin
    st_d          = st_q;
    i_d           = i_q;
    j_d           = j_q;
    jp_d          = jp_q;
    keep_d        = keep_q;
    piv_d         = piv_q;
    lsm_d         = lsm_q;
    rden_d        = rden_q;
    read_address  = '0;
    write_enable  = 1'b0;
    write_address = '0;
    write_data    = '0;
    s_set_lo      = 1'b0;
    s_set_hi      = 1'b0;
    s_set_pv      = 1'b0;
    s_push        = 1'b0;
    s_pop         = 1'b0;
    s_in_lo       = '0;
    s_in_hi       = '0;
    s_in_pv       = '0;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          s_set_lo = 1'b1;
          s_set_hi = 1'b1;
          s_set_pv = 1'b1;
          s_in_lo  = '0;
          s_in_hi  = '1;
          s_in_pv  = '0;
          rden_d   = 1'b1;
          st_d     = ST_LOOP;
        end
      end

      ST_LOOP: begin
        if (top_lo < top_hi) begin
          i_d          = top_lo;
          j_d          = top_lo + ADDR_W'(1);
          jp_d         = top_lo;
          read_address = top_hi;
          st_d         = ST_PIVOT;
        end else if (stk_empty) begin
          rden_d = 1'b0;
          st_d   = ST_IDLE;
        end else begin
          s_pop = 1'b1;
        end
      end

      ST_PIVOT: begin
        piv_d        = read_data;
        read_address = top_lo;
        st_d         = ST_SCAN;
      end

      ST_SCAN: begin
        if (read_data < piv_q) begin
          // first half of an exchange: old a[i] comes back next cycle
          write_enable  = 1'b1;
          write_address = i_q;
          write_data    = read_data;
          read_address  = i_q;
          i_d           = i_q + ADDR_W'(1);
          st_d          = ST_XCHG;
        end else if (jp_q == top_hi) begin
          // pivot word reached: put it at i and fetch the displaced word
          write_enable  = 1'b1;
          write_address = i_q;
          write_data    = piv_q;
          read_address  = i_q;
          st_d          = ST_PLACE;
        end else begin
          read_address = j_q;
          j_d          = j_q + ADDR_W'(1);
          jp_d         = j_q;
        end
      end

      ST_XCHG: begin
        write_enable  = 1'b1;
        write_address = jp_q;
        write_data    = read_data;
        read_address  = j_q;
        j_d           = j_q + ADDR_W'(1);
        jp_d          = j_q;
        st_d          = ST_SCAN;
      end

      ST_PLACE: begin
        write_enable  = 1'b1;
        write_address = top_hi;
        write_data    = read_data;
        s_set_pv      = 1'b1;
        s_in_pv       = i_q;
        st_d          = ST_NARROW;
      end

      ST_NARROW: begin
        lsm_d = left_small;
        if (left_small) begin
          keep_d   = top_lo;
          s_set_lo = 1'b1;
          s_in_lo  = pv_inc;
        end else begin
          keep_d   = top_hi;
          s_set_hi = 1'b1;
          s_in_hi  = pv_dec;
        end
        st_d = ST_DEFER;
      end

      ST_DEFER: begin
        s_in_pv = top_pv;
        if (lsm_q) begin
          s_in_lo = keep_q;
          s_in_hi = pv_dec;
          s_push  = !pv_at_min;
        end else begin
          s_in_lo = pv_inc;
          s_in_hi = keep_q;
          s_push  = !pv_at_max;
        end
        st_d = ST_LOOP;
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      i_q    <= '0;
      j_q    <= '0;
      jp_q   <= '0;
      keep_q <= '0;
      piv_q  <= '0;
      lsm_q  <= 1'b0;
      rden_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      i_q    <= i_d;
      j_q    <= j_d;
      jp_q   <= jp_d;
      keep_q <= keep_d;
      piv_q  <= piv_d;
      lsm_q  <= lsm_d;
      rden_q <= rden_d;
    end
  end

  assign done        = (st_q == ST_IDLE);
  assign read_enable = rden_q;

endmodule

// File: rtl/qsort_ctrl_chk.sv
module qsort_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int PW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          read_enable,
  input logic          write_enable,
  input logic [PW-1:0] stk_depth
);

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && read_enable));

  p_busy_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> read_enable);

  p_stack_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stk_depth) <= ADDR_W);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !write_enable);

  p_finish_drops_rden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !read_enable);

endmodule

bind qsort_ctrl qsort_ctrl_chk #(.ADDR_W(ADDR_W), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .done         (done),
  .read_enable  (read_enable),
  .write_enable (write_enable),
  .stk_depth    (stk_depth)
);

// File: tb/qsort_ctrl_bench.sv
module qsort_ctrl_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int N     = 1 << AW;
  localparam int LIMIT = 4 * N * N + 8 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, read_enable, write_enable;
  logic [AW-1:0] read_address, write_address;
  logic [DW-1:0] read_data, write_data;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] inp [N];
  logic [DW-1:0] expv [N];

  int errors = 0;
  int checks = 0;
  int ticks  = 0;

  always #2 clk = ~clk;

  // read-before-write RAM model
  always @(posedge clk) begin
    if (read_enable) read_data <= mem[read_address];
    if (write_enable) mem[write_address] <= write_data;
  end

  qsort_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_qsort_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .read_enable(read_enable), .read_address(read_address), .read_data(read_data),
    .write_enable(write_enable), .write_address(write_address), .write_data(write_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic void build_expected();
    for (int k = 0; k < N; k++) expv[k] = inp[k];
    for (int k = 1; k < N; k++) begin
      logic [DW-1:0] v = expv[k];
      int m = k - 1;
      while (m >= 0 && expv[m] > v) begin
        expv[m + 1] = expv[m];
        m--;
      end
      expv[m + 1] = v;
    end
  endfunction

  task automatic run_case(input string req, input bit poke);
    int cyc = 0;
    int rd_drops = 0;
    int bad = -1;
    for (int k = 0; k < N; k++) mem[k] = inp[k];
    build_expected();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && read_enable, "R2 start accepted", int'({done, read_enable}), 1);
    while (!done && cyc < LIMIT) begin
      if (!read_enable) rd_drops++;
      start = (poke && (cyc == 5 || cyc == 40));
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, "R6 finish bound", cyc, LIMIT);
    chk(rd_drops == 0, "R5 read_enable held while busy", rd_drops, 0);
    for (int k = N - 1; k >= 0; k--) if (mem[k] !== expv[k]) bad = k;
    if (bad >= 0) chk(1'b0, req, int'(mem[bad]), int'(expv[bad]));
    else chk(1'b1, req, 0, 0);
    repeat (3) @(negedge clk);
    chk(done && !write_enable, "R11 idle no writes", int'(write_enable), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(done && !read_enable && !write_enable, "R1 reset state",
        int'({done, read_enable, write_enable}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done && !read_enable && !write_enable, "R1 idle after reset",
        int'({done, read_enable, write_enable}), 4);

    // R3: random arrays
    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < N; k++) inp[k] = DW'($urandom);
      run_case("R3 random sorted permutation", 1'b0);
    end
    // R4: extra start pulses mid-run
    for (int k = 0; k < N; k++) inp[k] = DW'($urandom);
    run_case("R4 start ignored while busy", 1'b1);
    // R8: top-bit words mixed with small ones
    for (int k = 0; k < N; k++) inp[k] = (k % 2 == 0) ? DW'(8'h80 + k) : DW'(k);
    run_case("R8 unsigned ordering", 1'b0);
    // R9: duplicates, then all equal
    for (int k = 0; k < N; k++) inp[k] = DW'($urandom_range(0, 2));
    run_case("R9 duplicates", 1'b0);
    for (int k = 0; k < N; k++) inp[k] = 8'h5A;
    run_case("R9 all equal", 1'b0);
    // R10 / R7: degenerate orders that would deepen a naive stack
    for (int k = 0; k < N; k++) inp[k] = DW'(k * 3);
    run_case("R10 ascending input (R7 stack stays bounded)", 1'b0);
    for (int k = 0; k < N; k++) inp[k] = DW'(8'hFF - k);
    run_case("R10 descending input (R7 stack stays bounded)", 1'b0);
    // R3: many small words so the exchange collision repeats
    for (int k = 0; k < N; k++) inp[k] = (k == N - 1) ? 8'hF0 : DW'($urandom_range(0, 200));
    run_case("R3 exchange-heavy input", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule